// File: doc/BRIEF.md
# Output Buffer Source Arbiter

This block decides which of four producers owns the one-byte output buffer of a keyboard/mouse host controller. The producers are a controller-generated reply tagged for the keyboard channel, a controller reply tagged for the auxiliary (mouse) channel, a byte waiting in the keyboard device queue, and a byte waiting in the mouse device queue. Once a producer wins, the block raises the buffer-full flag and, for the auxiliary channel, the auxiliary-full flag. It records the owner and drives the two interrupt lines from those flags and the mode settings.

When the host reads the data port while the buffer is full, the block clears both flags and captures the byte from the recorded owner. For a device owner it pulses that device's pop strobe. Controller replies live in a one-byte holding register inside the block, and a newer reply overwrites an unread one. After a keyboard byte is read, an optional hold-off timer delays the next arbitration so a fast keyboard cannot flood the host.

Top module: `obuf_src_arb`

## Requirements
- R1: After reset, buffer-full, auxiliary-full, both interrupt lines, the read byte (0x00) and the owner code (0 = controller) are all low.
- R2: Fixed priority, highest first: keyboard-tagged controller reply, auxiliary-tagged controller reply, keyboard data, mouse data. The owner code is 0 for controller, 1 for keyboard and 2 for mouse.
- R3: A device pending level is ignored while its channel-off mode input is high. Controller replies are never masked.
- R4: When a winner is loaded, buffer-full goes high. Auxiliary-full goes high only when the winner is the auxiliary-tagged reply or mouse data.
- R5: Both interrupt lines are registered. The mouse line is high when the buffer is full, auxiliary-full is set and the mouse enable is on. The keyboard line is high when the buffer is full, auxiliary-full is clear, the keyboard enable is on and the keyboard channel is not off.
- R6: While the buffer is full and unread, new pending inputs or replies do not change the owner or the flags.
- R7: A read while the buffer is full clears both flags and both interrupts at that clock edge and captures the byte from the owner. A device owner also gets a one-cycle pop strobe during the read cycle. After a mouse read, arbitration resumes on the next edge.
- R8: A read while the buffer is empty leaves the read byte unchanged and pops nothing.
- R9: Reading a controller reply clears both reply flags and re-arbitrates at the same edge, so a waiting device byte owns the buffer right after the read.
- R10: With throttling on, after a keyboard byte is read, no arbitration happens for THROTTLE_CYC further edges. The buffer loads again on the edge after that.
- R11: A newly pushed reply replaces an unread one, both its byte and its tag.
- R12: Changing the mode inputs changes the interrupt lines one edge later and never changes the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rply_push_i | input | 1 | Load a controller reply into the holding register |
| rply_aux_i | input | 1 | Tag of the pushed reply: 1 auxiliary, 0 keyboard |
| rply_byte_i | input | DATA_W | Byte of the pushed reply |
| kbd_pend_i | input | 1 | Keyboard device queue holds a byte |
| aux_pend_i | input | 1 | Mouse device queue holds a byte |
| kbd_byte_i | input | DATA_W | Head byte of the keyboard queue |
| aux_byte_i | input | DATA_W | Head byte of the mouse queue |
| kbd_irq_en_i | input | 1 | Keyboard interrupt enable |
| aux_irq_en_i | input | 1 | Mouse interrupt enable |
| kbd_off_i | input | 1 | Keyboard channel off |
| aux_off_i | input | 1 | Mouse channel off |
| rd_i | input | 1 | Data-port read strobe |
| rd_byte_o | output | DATA_W | Last byte taken from the buffer |
| obf_o | output | 1 | Buffer full |
| aux_obf_o | output | 1 | Buffer full with auxiliary-channel data |
| owner_o | output | 2 | Owner code: 0 controller, 1 keyboard, 2 mouse |
| kbd_pop_o | output | 1 | Pop strobe to the keyboard queue |
| aux_pop_o | output | 1 | Pop strobe to the mouse queue |
| kbd_irq_o | output | 1 | Keyboard interrupt |
| aux_irq_o | output | 1 | Mouse interrupt |

## Verification
The bench builds the block with DATA_W of 8, throttling on and THROTTLE_CYC of 20 instead of a millisecond's worth of cycles. With these values the hold-off window can be observed edge by edge: the bench checks that the buffer is still empty on the last blocked edge and loaded on the next one. The short window also lets the bench compare a mouse read, which re-arms right away, with a keyboard read, which waits, within a few dozen cycles.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
   typedef enum logic [1:0] {
      OWN_CTRL = 2'd0,
      OWN_KBD  = 2'd1,
      OWN_AUX  = 2'd2
   } owner_e;

   localparam int unsigned NUM_SRC  = 4;
   localparam int unsigned SLOT_CK  = 0; // controller reply, keyboard tag
   localparam int unsigned SLOT_CA  = 1; // controller reply, aux tag
   localparam int unsigned SLOT_KBD = 2;
   localparam int unsigned SLOT_AUX = 3;
endpackage

// File: rtl/obuf_prio_pick.sv
module obuf_prio_pick #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);
   if (N < 2) begin : g_bad_n
      $error("obuf_prio_pick: N must be at least 2");
   end

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant_o[i]  = req_i[i] & ~seen[i];
      assign seen[i+1]   = seen[i] | req_i[i];
   end

   assign any_o = seen[N];
endmodule

// File: rtl/obuf_reply_hold.sv
module obuf_reply_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic              aux_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              clear_i,
   output logic [1:0]        flag_q_o,
   output logic [1:0]        flag_n_o,
   output logic [DATA_W-1:0] byte_o
);
   logic [1:0]        flag_q;
   logic [DATA_W-1:0] byte_q;

   always_comb begin
      flag_n_o = flag_q;
      if (push_i)       flag_n_o = aux_i ? 2'b10 : 2'b01;
      else if (clear_i) flag_n_o = 2'b00;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flag_q <= 2'b00;
         byte_q <= '0;
      end else begin
         flag_q <= flag_n_o;
         if (push_i) byte_q <= byte_i;
      end
   end

   assign flag_q_o = flag_q;
   assign byte_o   = byte_q;

   AST_ONE_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(flag_q)); // R11
endmodule

// File: rtl/obuf_throttle.sv
module obuf_throttle #(
   parameter bit          ENABLE = 1'b1,
   parameter int unsigned CYCLES = 100_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   if (CYCLES < 1) begin : g_bad_cyc
      $error("obuf_throttle: CYCLES must be at least 1");
   end

   if (ENABLE) begin : g_on
      localparam int unsigned CW = $clog2(CYCLES + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni)               cnt_q <= '0;
         else if (start_i)          cnt_q <= CW'(CYCLES);
         else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
      end

      assign busy_o = (cnt_q != '0);

      AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         start_i |=> busy_o); // R10
   end else begin : g_off
      assign busy_o = 1'b0 & start_i;
   end
endmodule

// File: rtl/obuf_src_arb.sv
module obuf_src_arb
   import obuf_arb_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter bit          THROTTLE_ON  = 1'b1,
   parameter int unsigned THROTTLE_CYC = 100_000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rply_push_i,
   input  logic              rply_aux_i,
   input  logic [DATA_W-1:0] rply_byte_i,
   input  logic              kbd_pend_i,
   input  logic              aux_pend_i,
   input  logic [DATA_W-1:0] kbd_byte_i,
   input  logic [DATA_W-1:0] aux_byte_i,
   input  logic              kbd_irq_en_i,
   input  logic              aux_irq_en_i,
   input  logic              kbd_off_i,
   input  logic              aux_off_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rd_byte_o,
   output logic              obf_o,
   output logic              aux_obf_o,
   output logic [1:0]        owner_o,
   output logic              kbd_pop_o,
   output logic              aux_pop_o,
   output logic              kbd_irq_o,
   output logic              aux_irq_o
);
   if (DATA_W < 1) begin : g_bad_w
      $error("obuf_src_arb: DATA_W must be at least 1");
   end

   logic              obf_q, aux_obf_q, kbd_irq_q, aux_irq_q;
   owner_e            own_q;
   logic [DATA_W-1:0] rd_byte_q;

   logic              take;
   logic              ctl_clear;
   logic [1:0]        ctl_flag_q, ctl_flag_n;
   logic [DATA_W-1:0] hold_byte;
   logic              thr_busy, thr_start;
   logic [1:0]        dev_req;
   logic [NUM_SRC-1:0] req_idle, req_reread, gnt_idle, gnt_reread;
   logic              any_idle, any_reread;

   logic              obf_n, aux_obf_n;
   owner_e            own_n;
   logic [DATA_W-1:0] rd_byte_n;

   assign take      = rd_i & obf_q;
   assign ctl_clear = take & (own_q == OWN_CTRL);
   assign thr_start = take & (own_q == OWN_KBD);
   assign kbd_pop_o = take & (own_q == OWN_KBD);
   assign aux_pop_o = take & (own_q == OWN_AUX);

   obuf_reply_hold #(.DATA_W(DATA_W)) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (rply_push_i),
      .aux_i    (rply_aux_i),
      .byte_i   (rply_byte_i),
      .clear_i  (ctl_clear),
      .flag_q_o (ctl_flag_q),
      .flag_n_o (ctl_flag_n),
      .byte_o   (hold_byte)
   );

   obuf_throttle #(.ENABLE(THROTTLE_ON), .CYCLES(THROTTLE_CYC)) u_thr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (thr_start),
      .busy_o  (thr_busy)
   );

   // device requests masked by the channel-off mode bits
   assign dev_req    = {aux_pend_i & ~aux_off_i, kbd_pend_i & ~kbd_off_i};
   assign req_idle   = {dev_req, ctl_flag_q};
   assign req_reread = {dev_req, ctl_flag_n};

   obuf_prio_pick #(.N(NUM_SRC)) u_pick_idle (
      .req_i   (req_idle),
      .grant_o (gnt_idle),
      .any_o   (any_idle)
   );

   obuf_prio_pick #(.N(NUM_SRC)) u_pick_reread (
      .req_i   (req_reread),
      .grant_o (gnt_reread),
      .any_o   (any_reread)
   );

   function automatic owner_e grant_owner(input logic [NUM_SRC-1:0] g);
      if (g[SLOT_CK] | g[SLOT_CA]) return OWN_CTRL;
      if (g[SLOT_KBD])             return OWN_KBD;
      return OWN_AUX;
   endfunction

   always_comb begin
      obf_n     = obf_q;
      aux_obf_n = aux_obf_q;
      own_n     = own_q;
      rd_byte_n = rd_byte_q;
      if (take) begin
         obf_n     = 1'b0;
         aux_obf_n = 1'b0;
         unique case (own_q)
            OWN_KBD: rd_byte_n = kbd_byte_i;
            OWN_AUX: rd_byte_n = aux_byte_i;
            default: rd_byte_n = hold_byte;
         endcase
         if ((own_q == OWN_CTRL) && any_reread) begin
            obf_n     = 1'b1;
            aux_obf_n = gnt_reread[SLOT_CA] | gnt_reread[SLOT_AUX];
            own_n     = grant_owner(gnt_reread);
         end
      end else if (!obf_q && !thr_busy && any_idle) begin
         obf_n     = 1'b1;
         aux_obf_n = gnt_idle[SLOT_CA] | gnt_idle[SLOT_AUX];
         own_n     = grant_owner(gnt_idle);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         obf_q     <= 1'b0;
         aux_obf_q <= 1'b0;
         own_q     <= OWN_CTRL;
         rd_byte_q <= '0;
         kbd_irq_q <= 1'b0;
         aux_irq_q <= 1'b0;
      end else begin
         obf_q     <= obf_n;
         aux_obf_q <= aux_obf_n;
         own_q     <= own_n;
         rd_byte_q <= rd_byte_n;
         kbd_irq_q <= obf_n & ~aux_obf_n & kbd_irq_en_i & ~kbd_off_i;
         aux_irq_q <= obf_n & aux_obf_n & aux_irq_en_i;
      end
   end

   assign obf_o     = obf_q;
   assign aux_obf_o = aux_obf_q;
   assign owner_o   = own_q;
   assign rd_byte_o = rd_byte_q;
   assign kbd_irq_o = kbd_irq_q;
   assign aux_irq_o = aux_irq_q;

   AST_AUX_IMPLIES_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aux_obf_q |-> obf_q); // R4
   AST_OWNER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (obf_q && !rd_i) |=> (obf_q && $stable(own_q) && $stable(aux_obf_q))); // R6
   AST_DEV_READ_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take && own_q != OWN_CTRL) |=> !obf_q); // R7
   AST_IDLE_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !obf_q) |=> $stable(rd_byte_q)); // R8
   AST_THROTTLE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_busy && !obf_q) |=> !obf_q); // R10
   AST_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(kbd_irq_q && aux_irq_q)); // R5
endmodule

// File: tb/obuf_src_arb_bench.sv
module obuf_src_arb_bench;
   localparam int unsigned DW  = 8;
   localparam int unsigned THR = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rply_push = 1'b0, rply_aux = 1'b0;
   logic [DW-1:0] rply_byte = '0;
   logic          kbd_pend = 1'b0, aux_pend = 1'b0;
   logic [DW-1:0] kbd_byte = 8'hA5, aux_byte = 8'h3C;
   logic          kbd_ien = 1'b1, aux_ien = 1'b1, kbd_off = 1'b0, aux_off = 1'b0;
   logic          rd = 1'b0;
   logic [DW-1:0] rd_byte;
   logic          obf, aux_obf, kbd_pop, aux_pop, kbd_irq, aux_irq;
   logic [1:0]    owner;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   obuf_src_arb #(.DATA_W(DW), .THROTTLE_ON(1'b1), .THROTTLE_CYC(THR)) u_obuf_src_arb (
      .clk_i(clk), .rst_ni(rst_n),
      .rply_push_i(rply_push), .rply_aux_i(rply_aux), .rply_byte_i(rply_byte),
      .kbd_pend_i(kbd_pend), .aux_pend_i(aux_pend),
      .kbd_byte_i(kbd_byte), .aux_byte_i(aux_byte),
      .kbd_irq_en_i(kbd_ien), .aux_irq_en_i(aux_ien),
      .kbd_off_i(kbd_off), .aux_off_i(aux_off),
      .rd_i(rd), .rd_byte_o(rd_byte), .obf_o(obf), .aux_obf_o(aux_obf),
      .owner_o(owner), .kbd_pop_o(kbd_pop), .aux_pop_o(aux_pop),
      .kbd_irq_o(kbd_irq), .aux_irq_o(aux_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic push(input logic [DW-1:0] b, input logic aux);
      rply_push = 1'b1; rply_byte = b; rply_aux = aux;
      step();
      rply_push = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 obf", obf, 0);
      check("R1 aux_obf", aux_obf, 0);
      check("R1 irqs", {kbd_irq, aux_irq}, 0);
      check("R1 owner", owner, 0);
      check("R1 rd_byte", rd_byte, 0);
   endtask

   task automatic t_priority();
      push(8'h55, 1'b0);
      step();
      check("R2 ctl owner", owner, 0);
      check("R4 ctl-kbd aux_obf", {obf, aux_obf}, 2'b10);
      check("R5 kbd irq", kbd_irq, 1);
      kbd_pend = 1'b1; aux_pend = 1'b1;
      rd = 1'b1; #1;
      check("R7 no pop on reply", {kbd_pop, aux_pop}, 0);
      step(); rd = 1'b0;
      check("R9 reply byte", rd_byte, 8'h55);
      check("R9 rearb keyboard", {obf, aux_obf, owner}, {2'b10, 2'd1});
      rd = 1'b1; #1;
      check("R7 kbd pop", {kbd_pop, aux_pop}, 2'b10);
      step(); rd = 1'b0; kbd_pend = 1'b0;
      check("R7 kbd byte", rd_byte, 8'hA5);
      check("R7 cleared", {obf, kbd_irq}, 0);
      repeat (THR) step();
      check("R10 still blocked", obf, 0);
      step();
      check("R10 rearm mouse", {obf, aux_obf, owner}, {2'b11, 2'd2});
      check("R5 mouse irq", {aux_irq, kbd_irq}, 2'b10);
      rd = 1'b1; #1;
      check("R7 aux pop", {kbd_pop, aux_pop}, 2'b01);
      step(); rd = 1'b0;
      check("R7 aux byte", rd_byte, 8'h3C);
      check("R7 aux cleared", {obf, aux_irq}, 0);
      step();
      check("R7 mouse no throttle", obf, 1);
      aux_pend = 1'b0;
      rd = 1'b1; step(); rd = 1'b0;
   endtask

   task automatic t_ctl_aux();
      kbd_off = 1'b1; kbd_pend = 1'b1;
      step(); step();
      check("R3 masked kbd", obf, 0);
      push(8'h81, 1'b1);
      step();
      check("R2 aux reply", {obf, aux_obf, owner}, {2'b11, 2'd0});
      check("R5 aux irq", {aux_irq, kbd_irq}, 2'b10);
      kbd_off = 1'b0;
      step();
      check("R12 owner kept", {obf, owner}, {1'b1, 2'd0});
      rd = 1'b1; step(); rd = 1'b0;
      check("R9 aux reply byte", rd_byte, 8'h81);
      check("R9 rearb kbd", {obf, aux_obf, owner, kbd_irq}, {2'b10, 2'd1, 1'b1});
      rd = 1'b1; step(); rd = 1'b0; kbd_pend = 1'b0;
      repeat (THR + 2) step();
      check("R10 idle after", obf, 0);
   endtask

   task automatic t_mask_irq();
      kbd_off = 1'b1;
      push(8'h11, 1'b0);
      step();
      check("R3 reply unmasked", {obf, owner}, {1'b1, 2'd0});
      check("R5 kbd off no irq", kbd_irq, 0);
      kbd_off = 1'b0; #1;
      check("R12 irq registered", kbd_irq, 0);
      step();
      check("R12 irq follows mode", kbd_irq, 1);
      kbd_ien = 1'b0;
      step();
      check("R12 irq disabled", {kbd_irq, obf, owner}, {2'b01, 2'd0});
      kbd_ien = 1'b1;
      rd = 1'b1; step(); rd = 1'b0;
      check("R7 reply read", {rd_byte, obf}, {8'h11, 1'b0});
   endtask

   task automatic t_replace();
      push(8'h22, 1'b0);
      step();
      check("R4 first reply", {obf, aux_obf}, 2'b10);
      push(8'h33, 1'b1);
      check("R6 flags held", {obf, aux_obf, owner}, {2'b10, 2'd0});
      aux_pend = 1'b1;
      step();
      check("R6 owner held", {obf, owner}, {1'b1, 2'd0});
      rd = 1'b1; step(); rd = 1'b0;
      check("R11 newest reply", rd_byte, 8'h33);
      check("R9 rearb mouse", {obf, aux_obf, owner}, {2'b11, 2'd2});
      rd = 1'b1; step(); rd = 1'b0; aux_pend = 1'b0;
      check("R7 mouse byte", rd_byte, 8'h3C);
      step();
      check("R7 empty", obf, 0);
      rd = 1'b1; #1;
      check("R8 no pop", {kbd_pop, aux_pop}, 0);
      step(); rd = 1'b0;
      check("R8 byte repeated", {rd_byte, obf}, {8'h3C, 1'b0});
   endtask

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_priority();
      t_ctl_aux();
      t_mask_irq();
      t_replace();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200_000 * 10);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule